// File: doc/BRIEF.md
# Indirect Banked Register Access Window

This block is a register file on a 16-bit management bus with 5-bit register addresses. Apart from its directly addressed registers, it offers an indirect window. Through that window a host reaches up to eight banks of 256 words each. The host puts the bank number and the word offset into a single control word. The same control word carries one command bit, which selects a read or a write. Bank 0 is an alias of the directly addressed registers. Banks 1 to 7 are internal storage arrays; in the usual map these are the miscellaneous, PCS and analog front-end banks, followed by spare banks. The serial bus framing is not part of the block: the host side is a parallel, single-cycle read and write port.

For an indirect write, the host first loads the write-data window (address 0x16). It then writes the control word (address 0x14) with the write bit set. For an indirect read, the host writes the control word with the read bit set, waits until `busy` falls, and then reads the read-data window (address 0x15).

A small sequencer carries out each command. It has three states:
- `S_IDLE`: waiting for a command.
- `S_ISSUE`: the bank access cycle.
- `S_CAPTURE`: the read result is loaded into the read-data window.

It has four transitions:
- `S_IDLE` to `S_ISSUE`: a valid command is accepted.
- `S_ISSUE` to `S_IDLE`: a write command completes.
- `S_ISSUE` to `S_CAPTURE`: a read command continues.
- `S_CAPTURE` to `S_IDLE`: a read command completes.

Top module: `ibw_window`

## Requirements
- R1: After reset, `busy` and `mgmt_rvalid` are 0, `mgmt_rdata` is 0, and every direct register and window register reads as 0.
- R2: A host write (`mgmt_wr`) to any address other than 0x14, 0x15 and 0x16 stores `mgmt_wdata` there. A host read (`mgmt_rd`) returns that register's value on `mgmt_rdata` in the next cycle, with `mgmt_rvalid` high for exactly that one cycle.
- R3: A control write (address 0x14) accepted while idle, with bit 11 set and bit 12 clear, is a write command. It stores the write-data window (address 0x16) at bank `wdata[10:8]` and offset `wdata[7:0]`, and holds `busy` high for exactly one cycle.
- R4: A control write accepted while idle, with bit 12 set and bit 11 clear, is a read command. It holds `busy` high for exactly two cycles. After that, the read-data window (address 0x15) holds the addressed word.
- R5: Reading address 0x14 returns the last accepted bank in bits [10:8] and the last accepted offset in bits [7:0]. Bits [15:11] read as 0, so the command bits are never stored.
- R6: A control write with bits 12 and 11 both set, or both clear, starts no command: `busy` stays low and no bank word changes. The bank and offset fields are still recorded for readback.
- R7: The read-data window changes only when a read command completes. Host writes to address 0x15 and write commands leave it unchanged.
- R8: A control write made while `busy` is high is ignored entirely: no command starts and the readback bank and offset keep their values.
- R9: Bank 0 offsets 0 to 31 alias the direct registers, so an indirect read returns what a direct read of that address returns. Indirect writes to bank 0 at offsets 0x14 to 0x16 are dropped. Bank 0 offsets of 32 and above read as 0 and drop writes.
- R10: The same offset in different banks refers to independent storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_addr | input | 5 | Register address for the current host access |
| mgmt_wr | input | 1 | Host write strobe |
| mgmt_rd | input | 1 | Host read strobe |
| mgmt_wdata | input | 16 | Host write data |
| mgmt_rdata | output | 16 | Read data, valid when `mgmt_rvalid` is high |
| mgmt_rvalid | output | 1 | One-cycle pulse in the cycle after a host read |
| busy | output | 1 | An indirect command is in progress |

## Verification
Some properties are checked on every cycle:
- the one-cycle read response,
- zero command bits in the control readback,
- whether a control write launches a command (one-hot command bits) or not (zero or two command bits),
- that the control fields hold still during a control write made while busy,
- that the read-data window changes only in `S_CAPTURE`.

Other behaviour is data-dependent and only the bench scenarios show it:
- that a word written to a given bank and offset comes back intact,
- that banks do not alias one another,
- how bank 0 maps onto the direct registers, including the dropped window offsets and the out-of-range offsets,
- the exact `busy` lengths of writes and reads.

// File: rtl/ibw_pkg.sv
package ibw_pkg;

    // Window register addresses on the management bus
    localparam logic [4:0] WIN_CTL_ADDR = 5'h14;
    localparam logic [4:0] WIN_RDW_ADDR = 5'h15;
    localparam logic [4:0] WIN_WRW_ADDR = 5'h16;

    // Indirect command sequencer states
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ISSUE   = 2'd1,
        S_CAPTURE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/ibw_direct_regs.sv
module ibw_direct_regs #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_data,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NREG];

    // One register per address; the window alias port wins on a same-address clash
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (a_we && a_addr == ADDR_W'(i)) begin
                q <= a_data;
            end else if (h_we && h_addr == ADDR_W'(i)) begin
                q <= h_data;
            end
        end
        assign regs[i] = q;
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

endmodule

// File: rtl/ibw_bank_store.sv
module ibw_bank_store #(
    parameter int DATA_W = 16,
    parameter int BANK_W = 3,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int NBANK = 1 << BANK_W;
    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] bank_rd [NBANK];

    // Bank 0 lives in the direct register file, not here
    assign bank_rd[0] = '0;

    for (genvar b = 1; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] arr [DEPTH];
        logic [DATA_W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (we && bank == BANK_W'(b)) begin
                arr[off] <= wdata;
            end
            if (re && bank == BANK_W'(b)) begin
                rd_q <= arr[off];
            end
        end
        assign bank_rd[b] = rd_q;
    end

    // bank is held stable by the sequencer across the capture cycle
    assign rdata = bank_rd[bank];

endmodule

// File: rtl/ibw_win_seq.sv
module ibw_win_seq
    import ibw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANK_W = 3,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              wrw_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] alias_rdata,
    input  logic [DATA_W-1:0] store_rdata,
    output seq_state_t        state,
    output logic              busy,
    output logic [BANK_W-1:0] ctl_bank,
    output logic [OFF_W-1:0]  ctl_off,
    output logic [DATA_W-1:0] wr_win,
    output logic [DATA_W-1:0] rd_win,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [OFF_W-1:0]  cmd_off,
    output logic              store_we,
    output logic              store_re,
    output logic              alias_we
);
    localparam int WR_POS = OFF_W + BANK_W;
    localparam int RD_POS = WR_POS + 1;

    seq_state_t        state_nx;
    logic              cmd_is_read;
    logic              accept;
    logic              launch;
    logic              alias_latch;
    logic              cap_en;
    logic              bank_is_zero;
    logic [DATA_W-1:0] alias_q;

    // Control writes count only while idle; exactly one command bit launches
    assign accept = ctl_we && (state == S_IDLE);
    assign launch = accept && (host_wdata[RD_POS] ^ host_wdata[WR_POS]);
    assign bank_is_zero = (cmd_bank == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (launch) state_nx = S_ISSUE;
            S_ISSUE:   state_nx = cmd_is_read ? S_CAPTURE : S_IDLE;
            S_CAPTURE: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        busy        = (state != S_IDLE);
        store_we    = (state == S_ISSUE) && !cmd_is_read && !bank_is_zero;
        store_re    = (state == S_ISSUE) &&  cmd_is_read && !bank_is_zero;
        alias_we    = (state == S_ISSUE) && !cmd_is_read &&  bank_is_zero;
        alias_latch = (state == S_ISSUE) &&  cmd_is_read;
        cap_en      = (state == S_CAPTURE);
    end

    // Window and command registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_bank    <= '0;
            ctl_off     <= '0;
            cmd_bank    <= '0;
            cmd_off     <= '0;
            cmd_is_read <= 1'b0;
            wr_win      <= '0;
            rd_win      <= '0;
            alias_q     <= '0;
        end else begin
            if (accept) begin
                ctl_bank <= host_wdata[WR_POS-1:OFF_W];
                ctl_off  <= host_wdata[OFF_W-1:0];
            end
            if (launch) begin
                cmd_bank    <= host_wdata[WR_POS-1:OFF_W];
                cmd_off     <= host_wdata[OFF_W-1:0];
                cmd_is_read <= host_wdata[RD_POS];
            end
            if (wrw_we) begin
                wr_win <= host_wdata;
            end
            if (alias_latch) begin
                alias_q <= alias_rdata;
            end
            if (cap_en) begin
                rd_win <= bank_is_zero ? alias_q : store_rdata;
            end
        end
    end

endmodule

// File: rtl/ibw_window.sv
module ibw_window
    import ibw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    parameter int BANK_W = 3,
    parameter int OFF_W  = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = WIN_CTL_ADDR,
    parameter logic [ADDR_W-1:0] RDW_ADDR = WIN_RDW_ADDR,
    parameter logic [ADDR_W-1:0] WRW_ADDR = WIN_WRW_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic              mgmt_wr,
    input  logic              mgmt_rd,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic [DATA_W-1:0] mgmt_rdata,
    output logic              mgmt_rvalid,
    output logic              busy
);
    seq_state_t        seq_state;
    logic [BANK_W-1:0] ctl_bank;
    logic [OFF_W-1:0]  ctl_off;
    logic [DATA_W-1:0] wr_win;
    logic [DATA_W-1:0] rd_win;
    logic [BANK_W-1:0] cmd_bank;
    logic [OFF_W-1:0]  cmd_off;
    logic              store_we;
    logic              store_re;
    logic              alias_we;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] ra_data;
    logic [DATA_W-1:0] rb_data;
    logic [DATA_W-1:0] ctl_word;
    logic [DATA_W-1:0] host_view;
    logic [DATA_W-1:0] alias_view;
    logic [ADDR_W-1:0] alias_addr;
    logic              alias_in_range;
    logic              host_dir_we;
    logic              alias_dir_we;

    function automatic logic is_window(input logic [ADDR_W-1:0] a);
        return (a == CTL_ADDR) || (a == RDW_ADDR) || (a == WRW_ADDR);
    endfunction

    function automatic logic [DATA_W-1:0] reg_view(
        input logic [ADDR_W-1:0] a,
        input logic [DATA_W-1:0] ctl_v,
        input logic [DATA_W-1:0] rdw_v,
        input logic [DATA_W-1:0] wrw_v,
        input logic [DATA_W-1:0] dir_v
    );
        if (a == CTL_ADDR)      return ctl_v;
        else if (a == RDW_ADDR) return rdw_v;
        else if (a == WRW_ADDR) return wrw_v;
        else                    return dir_v;
    endfunction

    assign ctl_word       = DATA_W'({ctl_bank, ctl_off});
    assign alias_addr     = cmd_off[ADDR_W-1:0];
    assign alias_in_range = ((cmd_off >> ADDR_W) == '0);
    assign host_dir_we    = mgmt_wr && !is_window(mgmt_addr);
    assign alias_dir_we   = alias_we && alias_in_range && !is_window(alias_addr);

    always_comb begin
        host_view  = reg_view(mgmt_addr, ctl_word, rd_win, wr_win, ra_data);
        alias_view = alias_in_range ? reg_view(alias_addr, ctl_word, rd_win, wr_win, rb_data) : '0;
    end

    ibw_win_seq #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .OFF_W  (OFF_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (mgmt_wr && mgmt_addr == CTL_ADDR),
        .wrw_we      (mgmt_wr && mgmt_addr == WRW_ADDR),
        .host_wdata  (mgmt_wdata),
        .alias_rdata (alias_view),
        .store_rdata (store_rdata),
        .state       (seq_state),
        .busy        (busy),
        .ctl_bank    (ctl_bank),
        .ctl_off     (ctl_off),
        .wr_win      (wr_win),
        .rd_win      (rd_win),
        .cmd_bank    (cmd_bank),
        .cmd_off     (cmd_off),
        .store_we    (store_we),
        .store_re    (store_re),
        .alias_we    (alias_we)
    );

    ibw_direct_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (host_dir_we),
        .h_addr  (mgmt_addr),
        .h_data  (mgmt_wdata),
        .a_we    (alias_dir_we),
        .a_addr  (alias_addr),
        .a_data  (wr_win),
        .ra_addr (mgmt_addr),
        .ra_data (ra_data),
        .rb_addr (alias_addr),
        .rb_data (rb_data)
    );

    ibw_bank_store #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .OFF_W  (OFF_W)
    ) u_store (
        .clk   (clk),
        .we    (store_we),
        .re    (store_re),
        .bank  (cmd_bank),
        .off   (cmd_off),
        .wdata (wr_win),
        .rdata (store_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_rdata  <= '0;
            mgmt_rvalid <= 1'b0;
        end else begin
            mgmt_rvalid <= mgmt_rd;
            if (mgmt_rd) begin
                mgmt_rdata <= host_view;
            end
        end
    end

endmodule

// File: rtl/ibw_checker.sv
module ibw_checker
    import ibw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    parameter int BANK_W = 3,
    parameter int OFF_W  = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = WIN_CTL_ADDR
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic              mgmt_wr,
    input logic              mgmt_rd,
    input logic [DATA_W-1:0] mgmt_wdata,
    input logic [DATA_W-1:0] mgmt_rdata,
    input logic              mgmt_rvalid,
    input logic              busy,
    input seq_state_t        seq_state,
    input logic [DATA_W-1:0] rd_win,
    input logic [BANK_W-1:0] ctl_bank,
    input logic [OFF_W-1:0]  ctl_off
);
    localparam int WR_POS = OFF_W + BANK_W;
    localparam int RD_POS = WR_POS + 1;

    logic ctl_hit;
    assign ctl_hit = mgmt_wr && (mgmt_addr == CTL_ADDR);

    a_r2_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rd |=> mgmt_rvalid);

    a_r2_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_rd |=> !mgmt_rvalid);

    a_r5_cmd_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && mgmt_addr == CTL_ADDR) |=> (mgmt_rdata[DATA_W-1:WR_POS] == '0));

    a_r3_onehot_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && !busy && (mgmt_wdata[RD_POS] != mgmt_wdata[WR_POS])) |=> busy);

    a_r6_bad_cmd_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && !busy && (mgmt_wdata[RD_POS] == mgmt_wdata[WR_POS])) |=> !busy);

    a_r4_capture_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_CAPTURE) |=> (seq_state == S_IDLE));

    a_r7_rdwin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != S_CAPTURE) |=> $stable(rd_win));

    a_r8_busy_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_hit && busy) |=> ($stable(ctl_bank) && $stable(ctl_off)));

endmodule

bind ibw_window ibw_checker #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .OFF_W    (OFF_W),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mgmt_addr   (mgmt_addr),
    .mgmt_wr     (mgmt_wr),
    .mgmt_rd     (mgmt_rd),
    .mgmt_wdata  (mgmt_wdata),
    .mgmt_rdata  (mgmt_rdata),
    .mgmt_rvalid (mgmt_rvalid),
    .busy        (busy),
    .seq_state   (seq_state),
    .rd_win      (rd_win),
    .ctl_bank    (ctl_bank),
    .ctl_off     (ctl_off)
);

// File: tb/ibw_window_test.sv
module ibw_window_test;

    localparam logic [4:0] CTL = 5'h14;
    localparam logic [4:0] RDW = 5'h15;
    localparam logic [4:0] WRW = 5'h16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic        mgmt_wr = 1'b0;
    logic        mgmt_rd = 1'b0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic        mgmt_rvalid;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    ibw_window uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mgmt_addr   (mgmt_addr),
        .mgmt_wr     (mgmt_wr),
        .mgmt_rd     (mgmt_rd),
        .mgmt_wdata  (mgmt_wdata),
        .mgmt_rdata  (mgmt_rdata),
        .mgmt_rvalid (mgmt_rvalid),
        .busy        (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each read response
    always @(negedge clk) begin
        if (rst_n && mgmt_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected rvalid", mgmt_rdata, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(mgmt_rdata === e, t, mgmt_rdata, e);
            end
        end
    end

    task automatic host_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        mgmt_addr = a;
        mgmt_wdata = d;
        mgmt_wr = 1'b1;
        @(negedge clk);
        mgmt_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        mgmt_addr = a;
        mgmt_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        mgmt_rd = 1'b0;
    endtask

    function automatic logic [15:0] ctl_val(input bit rd, input bit wr, input logic [2:0] b, input logic [7:0] o);
        return {3'b000, rd, wr, b, o};
    endfunction

    task automatic win_cmd(input bit rd, input logic [2:0] b, input logic [7:0] o);
        int n = 0;
        host_wr(CTL, ctl_val(rd, !rd, b, o));
        while (busy) begin
            n++;
            @(negedge clk);
        end
        if (rd) chk(n == 2, "R4 busy length", 16'(n), 16'd2);
        else    chk(n == 1, "R3 busy length", 16'(n), 16'd1);
    endtask

    task automatic bank_write(input logic [2:0] b, input logic [7:0] o, input logic [15:0] d);
        host_wr(WRW, d);
        win_cmd(1'b0, b, o);
    endtask

    task automatic bank_read(input logic [2:0] b, input logic [7:0] o, input logic [15:0] e, input string tag);
        win_cmd(1'b1, b, o);
        host_rd(RDW, e, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", 16'(busy), 16'h0);
        chk(mgmt_rvalid == 1'b0, "R1 rvalid", 16'(mgmt_rvalid), 16'h0);
        chk(mgmt_rdata == 16'h0, "R1 rdata", mgmt_rdata, 16'h0);
        host_rd(CTL, 16'h0, "R1 ctl reset");
        host_rd(RDW, 16'h0, "R1 rd window reset");
        host_rd(WRW, 16'h0, "R1 wr window reset");
        host_rd(5'h03, 16'h0, "R1 direct reset");

        // R2 direct access
        host_wr(5'h03, 16'h1234);
        host_wr(5'h1F, 16'hBEEF);
        host_rd(5'h03, 16'h1234, "R2 direct 03");
        host_rd(5'h1F, 16'hBEEF, "R2 direct 1f");
        // R7 host write to read window ignored
        host_wr(RDW, 16'h5555);
        host_rd(RDW, 16'h0, "R7 rd window not writable");

        // R3 R4 R10 bank writes and reads, same offset in several banks
        bank_write(3'd1, 8'h10, 16'hA001);
        bank_write(3'd2, 8'h10, 16'hB002);
        bank_write(3'd7, 8'hFF, 16'hC003);
        bank_write(3'd3, 8'h10, 16'hD004);
        bank_read(3'd1, 8'h10, 16'hA001, "R10 bank1 off10");
        bank_read(3'd2, 8'h10, 16'hB002, "R10 bank2 off10");
        bank_read(3'd7, 8'hFF, 16'hC003, "R4 bank7 offff");
        bank_read(3'd3, 8'h10, 16'hD004, "R10 bank3 off10");

        // R5 readback: last bank/offset, command bits zero
        host_rd(CTL, 16'h0310, "R5 ctl after read cmd");

        // R6 both bits set: no command, fields recorded
        host_wr(WRW, 16'h9999);
        host_wr(CTL, 16'hFB10);
        chk(busy == 1'b0, "R6 both bits no busy", 16'(busy), 16'h0);
        host_rd(CTL, 16'h0310, "R5 R6 ctl fields kept, cmd bits zero");
        host_wr(CTL, 16'h0105);
        chk(busy == 1'b0, "R6 no bits no busy", 16'(busy), 16'h0);
        host_rd(CTL, 16'h0105, "R6 ctl fields recorded");
        bank_read(3'd3, 8'h10, 16'hD004, "R6 bank word unchanged");

        // R7 write command leaves read window alone
        bank_write(3'd1, 8'h20, 16'h1111);
        host_rd(RDW, 16'hD004, "R7 rd window held over write cmd");

        // R8 control write during busy ignored
        bank_write(3'd5, 8'h33, 16'h2222);
        host_wr(WRW, 16'h7777);
        host_wr(CTL, ctl_val(1'b1, 1'b0, 3'd1, 8'h10));
        host_wr(CTL, ctl_val(1'b0, 1'b1, 3'd5, 8'h33));
        while (busy) @(negedge clk);
        host_rd(CTL, 16'h0110, "R8 ctl unchanged by busy write");
        host_rd(RDW, 16'hA001, "R8 first read completed");
        bank_read(3'd5, 8'h33, 16'h2222, "R8 no write from ignored cmd");

        // R9 bank 0 alias
        bank_write(3'd0, 8'h03, 16'h4321);
        host_rd(5'h03, 16'h4321, "R9 alias write reaches direct");
        host_wr(5'h07, 16'h0707);
        bank_read(3'd0, 8'h07, 16'h0707, "R9 alias read of direct");
        bank_write(3'd0, 8'h40, 16'hFFFF);
        bank_read(3'd0, 8'h40, 16'h0000, "R9 out of range reads zero");
        bank_write(3'd0, 8'h15, 16'h6666);
        host_rd(RDW, 16'h0000, "R9 alias write to window dropped");
        bank_write(3'd0, 8'h16, 16'h1357);
        bank_read(3'd0, 8'h14, 16'h0014, "R9 alias read of control");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 responses outstanding", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual %h expected %h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule